// File: doc/BRIEF.md
# Sequential Saturating Ratio Divider

This block computes a scaling ratio from an unsigned numerator and an unsigned denominator without a single-cycle divide operator, so synthesis never has to build a wide combinational divider. It places 24 zero fraction bits below the 12-bit numerator to form a 36-bit dividend. It then runs a restoring shift-and-subtract loop that settles one quotient bit per clock. When the loop ends, it returns a 10-bit field cut from the quotient. A zero denominator skips the loop and saturates the quotient to all ones.

A request arrives on a valid/ready pair. `in_ready` is high whenever the divider is idle. A request is taken on a rising edge where `in_valid` and `in_ready` are both high. While a division runs, `in_ready` stays low, and the requester must hold its request until it is accepted. The result side has no back-pressure. `done` pulses for one cycle when `ratio` gets a new value, and `ratio` then keeps that value until the next request completes. The added latency therefore reaches the consumer through `busy`, `in_ready` and `done`.

Top module: `ratio_divider`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `busy`, `done` and `ratio` are 0 and `in_ready` is 1.
- R2: A request is accepted only on a rising edge with `in_valid` and `in_ready` both high. `in_ready` is low while `busy` is high, and a request presented then is dropped: it starts no division and produces no `done`.
- R3: For a nonzero denominator, `busy` rises at the accepting edge and falls at the 36th rising edge after it. `done` is high in the cycle that follows that 36th edge.
- R4: For a nonzero denominator, `ratio` equals bits 33 down to 24 of the 36-bit quotient floor((num_i × 2^24) / den_i) after zero extension to 39 bits. That field is the integer quotient modulo 1024, so 4095/1 gives 0x3FF.
- R5: For a zero denominator, `busy` stays low, `done` is high in the cycle right after the accepting edge, and `ratio` is 0x3FF, which is the field taken from a quotient forced to 36 one-bits.
- R6: `done` is high for exactly one cycle per completed division, and `done` is never high while `busy` is high.
- R7: `ratio` changes only at an edge that also raises `done`. Between completions it holds its value.
- R8: The operands are captured at the accepting edge. Changing `num_i` or `den_i` afterwards does not alter the result of the division in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Divider idle and able to take a request |
| num_i | input | 12 | Unsigned numerator |
| den_i | input | 12 | Unsigned denominator |
| busy | output | 1 | Division loop running |
| done | output | 1 | One-cycle pulse when `ratio` is updated |
| ratio | output | 10 | Quotient bits 33..24 |

## Verification
The bench builds the divider with its default widths: a 12-bit numerator and denominator, 24 fraction bits, a 3-bit extension and a 10-bit field at bit 24. These values make the full 36-step loop run, so the cycle count is checked at its real length. They also make integer quotients above 1023 reachable, which exercises the wrap of the sliced field, for example 2048/1 giving 0. Directed requests cover the largest numerator over 1, a zero numerator, equal operands and zero denominators. Seeded random requests mix in further zero denominators, operands that change in mid-run, and requests presented while the divider is busy.

// File: rtl/ratio_div_pkg.sv
package ratio_div_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } div_state_t;
endpackage

// File: rtl/ratio_div_ctrl.sv
module ratio_div_ctrl
  import ratio_div_pkg::*;
#(
  parameter int STEPS = 36
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic den_zero,
  output logic in_ready,
  output logic busy,
  output logic load,
  output logic sat,
  output logic step,
  output logic last,
  output logic done
);
  localparam int CNT_W = $clog2(STEPS + 1);

  div_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             accept;

  assign busy     = (state_q == ST_RUN);
  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;
  assign load     = accept && !den_zero;
  assign sat      = accept && den_zero;
  assign step     = busy;
  assign last     = busy && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done    <= 1'b0;
    end else begin
      done <= last || sat;
      if (load) begin
        state_q <= ST_RUN;
        cnt_q   <= CNT_W'(STEPS);
      end else if (step) begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (last) state_q <= ST_IDLE;
      end
    end
  end
endmodule

// File: rtl/ratio_div_core.sv
module ratio_div_core #(
  parameter int NUM_W  = 12,
  parameter int DEN_W  = 12,
  parameter int FRAC_W = 24
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  logic                      step,
  input  logic [NUM_W-1:0]          num,
  input  logic [DEN_W-1:0]          den,
  output logic [NUM_W+FRAC_W-1:0]   quo_next
);
  localparam int QW = NUM_W + FRAC_W;

  // Dividend bits leave at the top while quotient bits enter at the bottom.
  logic [QW-1:0]    dq_q;
  logic [DEN_W-1:0] rem_q;
  logic [DEN_W-1:0] den_q;
  logic [DEN_W:0]   shifted;
  logic [DEN_W:0]   unused_diff;
  logic [DEN_W-1:0] rem_next;
  logic             ge;

  assign shifted     = {rem_q, dq_q[QW-1]};
  assign ge          = shifted >= {1'b0, den_q};
  assign unused_diff = shifted - {1'b0, den_q};
  assign rem_next    = ge ? unused_diff[DEN_W-1:0] : shifted[DEN_W-1:0];
  assign quo_next    = {dq_q[QW-2:0], ge};

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_q  <= '0;
      rem_q <= '0;
      den_q <= '0;
    end else if (load) begin
      dq_q  <= {num, {FRAC_W{1'b0}}};
      rem_q <= '0;
      den_q <= den;
    end else if (step) begin
      dq_q  <= quo_next;
      rem_q <= rem_next;
    end
  end
endmodule

// File: rtl/ratio_div_result.sv
module ratio_div_result #(
  parameter int QUO_W   = 36,
  parameter int EXT_W   = 3,
  parameter int OUT_LSB = 24,
  parameter int OUT_W   = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  logic             saturate,
  input  logic [QUO_W-1:0] quo_in,
  output logic [OUT_W-1:0] ratio
);
  localparam int WIDE_W = QUO_W + EXT_W;

  logic [WIDE_W-1:0] unused_wide;

  assign unused_wide = {{EXT_W{1'b0}}, (saturate ? {QUO_W{1'b1}} : quo_in)};

  always_ff @(posedge clk) begin
    if (rst) begin
      ratio <= '0;
    end else if (capture || saturate) begin
      ratio <= unused_wide[OUT_LSB +: OUT_W];
    end
  end
endmodule

// File: rtl/ratio_divider.sv
module ratio_divider #(
  parameter int NUM_W   = 12,
  parameter int DEN_W   = 12,
  parameter int FRAC_W  = 24,
  parameter int EXT_W   = 3,
  parameter int OUT_LSB = 24,
  parameter int OUT_W   = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             busy,
  output logic             done,
  output logic [OUT_W-1:0] ratio
);
  localparam int QUO_W = NUM_W + FRAC_W;

  logic             den_zero;
  logic             load;
  logic             sat;
  logic             step;
  logic             last;
  logic [QUO_W-1:0] quo_next;

  assign den_zero = (den_i == '0);

  ratio_div_ctrl #(.STEPS(QUO_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .den_zero (den_zero),
    .in_ready (in_ready),
    .busy     (busy),
    .load     (load),
    .sat      (sat),
    .step     (step),
    .last     (last),
    .done     (done)
  );

  ratio_div_core #(.NUM_W(NUM_W), .DEN_W(DEN_W), .FRAC_W(FRAC_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .step     (step),
    .num      (num_i),
    .den      (den_i),
    .quo_next (quo_next)
  );

  ratio_div_result #(.QUO_W(QUO_W), .EXT_W(EXT_W), .OUT_LSB(OUT_LSB), .OUT_W(OUT_W)) u_res (
    .clk      (clk),
    .rst      (rst),
    .capture  (last),
    .saturate (sat),
    .quo_in   (quo_next),
    .ratio    (ratio)
  );
endmodule

// File: rtl/ratio_divider_chk.sv
module ratio_divider_chk #(
  parameter int QUO_W = 36,
  parameter int DEN_W = 12,
  parameter int OUT_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [DEN_W-1:0] den_i,
  input logic             busy,
  input logic             done,
  input logic [OUT_W-1:0] ratio
);
  localparam int CW = $clog2(QUO_W + 2) + 1;

  logic [CW-1:0] run_cnt;
  logic          take;

  assign take = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) run_cnt <= '0;
    else if (take) run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + CW'(1);
  end

  p_start_run_r3: assert property (@(posedge clk) disable iff (rst)
    (take && den_i != '0) |=> (busy && !done));

  p_run_length_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (done && run_cnt == CW'(QUO_W)));

  p_zero_sat_r5: assert property (@(posedge clk) disable iff (rst)
    (take && den_i == '0) |=> (done && !busy && ratio == '1));

  p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_ratio_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(ratio));

  p_no_take_busy_r2: assert property (@(posedge clk) disable iff (rst)
    busy |-> !in_ready);
endmodule

bind ratio_divider ratio_divider_chk #(
  .QUO_W (NUM_W + FRAC_W),
  .DEN_W (DEN_W),
  .OUT_W (OUT_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .den_i    (den_i),
  .busy     (busy),
  .done     (done),
  .ratio    (ratio)
);

// File: tb/ratio_divider_test.sv
module ratio_divider_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [11:0] num_i = '0;
  logic [11:0] den_i = '0;
  logic        busy;
  logic        done;
  logic [9:0]  ratio;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #10 clk = ~clk;

  ratio_divider uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .num_i(num_i), .den_i(den_i), .busy(busy), .done(done), .ratio(ratio)
  );

  function automatic logic [9:0] ref_ratio(input logic [11:0] n, input logic [11:0] d);
    logic [35:0] q;
    if (d == 12'd0) return 10'h3FF;
    q = {n, 24'd0} / {24'd0, d};
    return q[33:24];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic run_op(input logic [11:0] n, input logic [11:0] d, input bit poke);
    logic [9:0] exp;
    int lat;
    int exp_lat;
    exp = ref_ratio(n, d);
    exp_lat = (d == 12'd0) ? 0 : 36;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; num_i = n; den_i = d;
    @(posedge clk); #1;
    // R8: scramble operands after acceptance
    num_i = 12'($urandom); den_i = 12'($urandom);
    if (!poke) in_valid = 1'b0;
    lat = 0;
    if (busy) check(!in_ready, "R2 ready low while busy", in_ready, 0);
    while (!done && lat < 100) begin
      @(posedge clk); #1;
      lat++;
    end
    in_valid = 1'b0;
    check(lat == exp_lat, (d == 0) ? "R5 latency" : "R3 latency", lat, exp_lat);
    check(ratio == exp && !busy, (d == 0) ? "R5 saturated ratio" : "R4 R8 ratio", ratio, exp);
    @(posedge clk); #1;
    check(!done && !busy, poke ? "R2 R6 no extra run" : "R6 done pulse", {busy, done}, 0);
    check(ratio == exp, "R7 ratio holds", ratio, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    check(!busy && !done && ratio == 0 && in_ready, "R1 reset held", {busy, done, ratio}, 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check(!busy && !done, "R1 after release", {busy, done}, 0);
    check(ratio == 10'd0, "R1 ratio cleared", ratio, 0);
    check(in_ready, "R1 ready", in_ready, 1);

    run_op(12'd4095, 12'd1, 0);
    run_op(12'd5, 12'd0, 0);
    run_op(12'd0, 12'd7, 0);
    run_op(12'd1, 12'd4095, 1);
    run_op(12'd4095, 12'd4095, 0);
    run_op(12'd3000, 12'd3, 1);
    run_op(12'd2048, 12'd1, 0);
    run_op(12'd0, 12'd0, 1);
    for (int i = 0; i < 40; i++) begin
      logic [11:0] rn;
      logic [11:0] rd;
      rn = 12'($urandom);
      rd = (($urandom % 8) == 0) ? 12'd0 : 12'($urandom % 64);
      run_op(rn, rd, bit'($urandom % 2));
    end
    finish_run();
  end
endmodule